// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns a single asynchronous serial line into parallel characters. A prescaler divides the system clock by a reload value plus one, giving a tick at sixteen times the bit rate. A framing engine waits for the line to fall and confirms the start bit halfway through it. It then samples every data, parity and stop bit at its centre. The data length, the parity mode and the number of stop bits are configuration inputs. The engine latches them when a start bit is detected.

A finished character moves from the shift register into a receive buffer. If the buffer was empty, a one-cycle receive interrupt is raised. If a character arrives while the previous one is still unread, the buffer takes the new character anyway, the overrun flag is set, and no interrupt is raised. Framing and parity flags describe the character in the buffer. An error-sum output is the OR of the three error flags. The host acknowledges a character with a one-cycle read strobe, and a ready output tells the far end whether the buffer can accept a character.

Top module: `uart_rx_core`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle: a frame on `rxd` sets no buffer state, raises no interrupt and changes no flag.
- R2: One bit lasts 16 ticks, and a tick occurs every `reload`+1 clock cycles, so one bit time is 16×(`reload`+1) clocks.
- R3: A falling edge starts a candidate start bit, which is confirmed by a low sample 8 ticks later. If that sample is high, the candidate is dropped and the receiver returns to idle without storing anything.
- R4: Data bits arrive least-significant bit first. `len_sel` = 0, 1 or 2 selects 7, 8 or 9 data bits, and unused upper bits of `rx_data` read as 0.
- R5: `par_sel` = 0 means no parity bit, 1 means odd parity and 2 means even parity. `par_err` is set when the count of ones across the data and parity bits does not match the selected mode.
- R6: `two_stop` = 0 checks one stop bit and 1 checks two. `frm_err` is set when any checked stop bit samples low.
- R7: A completed character is written to `rx_data` and sets `buf_full`. If the buffer was empty, `rx_irq` is high for exactly one cycle.
- R8: A character that completes while `buf_full` is 1 and no read is under way still overwrites `rx_data`. It sets `ovr_err` and raises no `rx_irq`.
- R9: A one-cycle `rd_strobe` clears `buf_full` and `ovr_err`. `par_err` and `frm_err` are rewritten with every new character.
- R10: `err_sum` is 1 exactly when `ovr_err`, `frm_err` or `par_err` is 1.
- R11: `rx_ready` is the inverse of `buf_full`.
- R12: After a synchronous reset, `buf_full`, `rx_irq` and all error outputs are 0, and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial line, idle high |
| reload | input | 8 | Prescaler reload value n; tick period is n+1 clocks |
| len_sel | input | 2 | Data length select: 0 = 7, 1 = 8, 2 = 9 bits |
| par_sel | input | 2 | Parity select: 0 = none, 1 = odd, 2 = even |
| two_stop | input | 1 | 1 = two stop bits checked |
| rd_strobe | input | 1 | One-cycle acknowledge of the buffered character |
| rx_data | output | 9 | Received character |
| buf_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | One-cycle receive interrupt |
| ovr_err | output | 1 | Overrun error |
| frm_err | output | 1 | Framing error of the buffered character |
| par_err | output | 1 | Parity error of the buffered character |
| err_sum | output | 1 | OR of the three error flags |
| rx_ready | output | 1 | Buffer can accept a character |

## Verification
The assertions assume three things about the inputs. The configuration and `reload` stay constant while a frame is in flight. `rd_strobe` lasts a single cycle. `rxd` holds each bit level for a whole bit time, apart from deliberately short glitches. The stimulus changes configuration and `reload` only while the line is idle and every earlier frame is complete. It drives each bit for exactly 16×(`reload`+1) clocks and pulses the read strobe for one clock between frames. A stop bit marked bad is held low for only three quarters of a bit, so the line returns high before the receiver could confirm a false start bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OVS      = 16;
    localparam int SUB_W    = $clog2(OVS);
    localparam int MAX_BITS = 9;
    localparam int IDX_W    = $clog2(MAX_BITS);

    typedef enum logic [1:0] {
        LEN_7 = 2'd0,
        LEN_8 = 2'd1,
        LEN_9 = 2'd2,
        LEN_X = 2'd3
    } len_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_OFF  = 2'd3
    } par_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        len_e len;
        par_e par;
        logic two_stop;
    } rx_cfg_t;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                perr;
        logic                ferr;
    } rx_char_t;

    function automatic logic [IDX_W-1:0] char_bits(input len_e l);
        case (l)
            LEN_7:   char_bits = IDX_W'(7);
            LEN_8:   char_bits = IDX_W'(8);
            default: char_bits = IDX_W'(9);
        endcase
    endfunction

    function automatic logic parity_on(input par_e p);
        parity_on = (p == PAR_ODD) || (p == PAR_EVEN);
    endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [RW-1:0] reload,
    output logic          tick
);
    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)        cnt <= '0;
        else if (cnt >= reload) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt >= reload);

    // R2: with a nonzero, steady reload, two ticks never come back to back
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && reload != '0 && en) |=> (!tick || !$stable(reload)));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     tick,
    input  logic     rxd,
    input  rx_cfg_t  cfg,
    output logic     done,
    output rx_char_t char_q
);
    localparam logic [SUB_W-1:0] START_CHK = SUB_W'(OVS/2 - 1);
    localparam logic [SUB_W-1:0] MID_CHK   = SUB_W'(OVS - 1);

    logic                rxd_m, rxd_s;
    rx_state_e           state;
    logic [SUB_W-1:0]    sub;
    logic [IDX_W-1:0]    idx;
    logic [MAX_BITS-1:0] shreg;
    logic                pacc, perr_r, ferr_r;
    rx_cfg_t             cfg_q;
    logic                mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd;
            rxd_s <= rxd_m;
        end
    end

    assign mid = (sub == MID_CHK);

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            state  <= ST_IDLE;
            sub    <= '0;
            idx    <= '0;
            shreg  <= '0;
            pacc   <= 1'b0;
            perr_r <= 1'b0;
            ferr_r <= 1'b0;
            cfg_q  <= '0;
            char_q <= '0;
        end else if (!en) begin
            state <= ST_IDLE;
        end else if (tick) begin
            sub <= sub + 1'b1;
            unique case (state)
                ST_IDLE: begin
                    sub <= '0;
                    if (!rxd_s) begin
                        state <= ST_START;
                        cfg_q <= cfg;
                    end
                end
                ST_START: begin
                    if (sub == START_CHK) begin
                        sub <= '0;
                        if (rxd_s) begin
                            state <= ST_IDLE;
                        end else begin
                            state  <= ST_DATA;
                            idx    <= '0;
                            shreg  <= '0;
                            pacc   <= 1'b0;
                            perr_r <= 1'b0;
                            ferr_r <= 1'b0;
                        end
                    end
                end
                ST_DATA: begin
                    if (mid) begin
                        shreg[idx] <= rxd_s;
                        pacc       <= pacc ^ rxd_s;
                        if (idx == char_bits(cfg_q.len) - 1'b1) begin
                            idx   <= '0;
                            state <= parity_on(cfg_q.par) ? ST_PAR : ST_STOP1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (mid) begin
                        perr_r <= ((pacc ^ rxd_s) != (cfg_q.par == PAR_ODD));
                        state  <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (mid) begin
                        if (cfg_q.two_stop) begin
                            ferr_r <= !rxd_s;
                            state  <= ST_STOP2;
                        end else begin
                            char_q.data <= shreg;
                            char_q.perr <= perr_r;
                            char_q.ferr <= !rxd_s;
                            done        <= 1'b1;
                            state       <= ST_IDLE;
                        end
                    end
                end
                ST_STOP2: begin
                    if (mid) begin
                        char_q.data <= shreg;
                        char_q.perr <= perr_r;
                        char_q.ferr <= ferr_r | !rxd_s;
                        done        <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a disabled receiver drops back to idle
    p_disabled_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == ST_IDLE && !done));

    // R3: a high sample at the confirmation tick abandons the start bit
    p_glitch_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (en && tick && state == ST_START && sub == START_CHK && rxd_s)
        |=> (state == ST_IDLE && !done));

    // R6: a low single stop bit finishes the character with a framing error
    p_stop_low_r6: assert property (@(posedge clk) disable iff (rst)
        (en && tick && state == ST_STOP1 && mid && !cfg_q.two_stop && !rxd_s)
        |=> (done && char_q.ferr));

    // R7: completion is a single-cycle event
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  rx_char_t            char_in,
    input  logic                rd,
    output logic [MAX_BITS-1:0] data,
    output logic                full,
    output logic                irq,
    output logic                ovr,
    output logic                frm,
    output logic                par
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            irq  <= 1'b0;
            ovr  <= 1'b0;
            frm  <= 1'b0;
            par  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (done) begin
                data <= char_in.data;
                frm  <= char_in.ferr;
                par  <= char_in.perr;
                full <= 1'b1;
                if (full && !rd) begin
                    ovr <= 1'b1;
                end else begin
                    ovr <= 1'b0;
                    irq <= 1'b1;
                end
            end else if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
            end
        end
    end

    // R8: an unread buffer hit by a new character flags overrun, no interrupt
    p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
        (done && full && !rd) |=> (ovr && !irq && full));

    // R9: a read with no arriving character empties the buffer
    p_read_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd && !done) |=> (!full && !ovr));

    // R7: an interrupt always comes with a filled buffer
    p_irq_full_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> full);

    // R7: interrupt only follows a completed character
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(done));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       rxd,
    input  logic [7:0] reload,
    input  logic [1:0] len_sel,
    input  logic [1:0] par_sel,
    input  logic       two_stop,
    input  logic       rd_strobe,
    output logic [8:0] rx_data,
    output logic       buf_full,
    output logic       rx_irq,
    output logic       ovr_err,
    output logic       frm_err,
    output logic       par_err,
    output logic       err_sum,
    output logic       rx_ready
);
    logic     tick;
    logic     done;
    rx_char_t char_w;
    rx_cfg_t  cfg;

    assign cfg.len      = len_e'(len_sel);
    assign cfg.par      = par_e'(par_sel);
    assign cfg.two_stop = two_stop;

    uart_rx_tick #(.RW(8)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .en     (rx_en),
        .reload (reload),
        .tick   (tick)
    );

    uart_rx_frame u_frame (
        .clk    (clk),
        .rst    (rst),
        .en     (rx_en),
        .tick   (tick),
        .rxd    (rxd),
        .cfg    (cfg),
        .done   (done),
        .char_q (char_w)
    );

    uart_rx_buffer u_buf (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .char_in (char_w),
        .rd      (rd_strobe),
        .data    (rx_data),
        .full    (buf_full),
        .irq     (rx_irq),
        .ovr     (ovr_err),
        .frm     (frm_err),
        .par     (par_err)
    );

    assign err_sum  = ovr_err | frm_err | par_err;
    assign rx_ready = !buf_full;

    // R10: an overrun alone is enough to raise the summary flag
    p_sum_ovr_r10: assert property (@(posedge clk) disable iff (rst)
        ovr_err |-> err_sum);

    // R11: a ready line and a full buffer never coexist
    p_ready_full_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> !rx_ready);
endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;

    typedef struct packed {
        logic [8:0] d;
        logic [1:0] len;
        logic [1:0] par;
        logic       two;
        logic       flip;
        logic       bad;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{d: 9'h055, len: 2'd1, par: 2'd0, two: 1'b0, flip: 1'b0, bad: 1'b0},
        '{d: 9'h1A5, len: 2'd2, par: 2'd2, two: 1'b0, flip: 1'b0, bad: 1'b0},
        '{d: 9'h03C, len: 2'd0, par: 2'd1, two: 1'b1, flip: 1'b0, bad: 1'b0},
        '{d: 9'h0A3, len: 2'd1, par: 2'd2, two: 1'b0, flip: 1'b1, bad: 1'b0},
        '{d: 9'h00F, len: 2'd1, par: 2'd1, two: 1'b0, flip: 1'b0, bad: 1'b1},
        '{d: 9'h100, len: 2'd2, par: 2'd0, two: 1'b1, flip: 1'b0, bad: 1'b0},
        '{d: 9'h1FE, len: 2'd0, par: 2'd2, two: 1'b1, flip: 1'b1, bad: 1'b0},
        '{d: 9'h0FF, len: 2'd1, par: 2'd1, two: 1'b1, flip: 1'b0, bad: 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] reload = 8'd1;
    logic [1:0] len_sel = 2'd1;
    logic [1:0] par_sel = 2'd0;
    logic       two_stop = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       buf_full, rx_irq, ovr_err, frm_err, par_err, err_sum, rx_ready;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_rx_core u_uart_rx_core (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rxd(rxd), .reload(reload),
        .len_sel(len_sel), .par_sel(par_sel), .two_stop(two_stop),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .buf_full(buf_full),
        .rx_irq(rx_irq), .ovr_err(ovr_err), .frm_err(frm_err),
        .par_err(par_err), .err_sum(err_sum), .rx_ready(rx_ready)
    );

    always @(negedge clk) if (rx_irq) irq_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] mask_len(input logic [8:0] d, input logic [1:0] l);
        case (l)
            2'd0:    mask_len = d & 9'h07F;
            2'd1:    mask_len = d & 9'h0FF;
            default: mask_len = d;
        endcase
    endfunction

    function automatic int nbits(input logic [1:0] l);
        nbits = (l == 2'd0) ? 7 : (l == 2'd1) ? 8 : 9;
    endfunction

    task automatic hold(input logic v, input int clocks);
        rxd = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send(input vec_t v);
        int bp;
        logic [8:0] m;
        logic pbit;
        bp = 16 * (int'(reload) + 1);
        m = mask_len(v.d, v.len);
        len_sel = v.len;
        par_sel = v.par;
        two_stop = v.two;
        @(negedge clk);
        hold(1'b0, bp);
        for (int i = 0; i < nbits(v.len); i++) hold(m[i], bp);
        if (v.par != 2'd0) begin
            pbit = (v.par == 2'd1) ? ~(^m) : (^m);
            hold(pbit ^ v.flip, bp);
        end
        if (v.bad) begin
            hold(1'b0, (bp * 3) / 4);
            hold(1'b1, bp - (bp * 3) / 4);
        end else begin
            hold(1'b1, bp);
        end
        if (v.two) hold(1'b1, bp);
        hold(1'b1, 2 * bp);
    endtask

    task automatic read_pulse();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int irq0;
        vec_t w;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check("R12 buf_full", buf_full, 0);
        check("R12 errors", {ovr_err, frm_err, par_err, err_sum}, 0);
        check("R12 ready", rx_ready, 1);
        check("R12 irq", rx_irq, 0);

        // R1: disabled receiver ignores a frame
        irq0 = irq_cnt;
        send(VECS[0]);
        check("R1 no store", buf_full, 0);
        check("R1 no irq", irq_cnt - irq0, 0);
        check("R1 flags", err_sum, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk: R4 R5 R6 R7 R9 R10 R11
        for (int k = 0; k < NV; k++) begin
            irq0 = irq_cnt;
            send(VECS[k]);
            check("R4 data", rx_data, mask_len(VECS[k].d, VECS[k].len));
            check("R5 par_err", par_err, VECS[k].flip);
            check("R6 frm_err", frm_err, VECS[k].bad);
            check("R10 err_sum", err_sum, VECS[k].flip | VECS[k].bad);
            check("R7 irq once", irq_cnt - irq0, 1);
            check("R7 buf_full", buf_full, 1);
            check("R11 ready low", rx_ready, 0);
            read_pulse();
            check("R9 full cleared", buf_full, 0);
            check("R11 ready high", rx_ready, 1);
        end

        // R8: overrun keeps the newer character, no second interrupt
        irq0 = irq_cnt;
        w = '{d: 9'h0C3, len: 2'd1, par: 2'd0, two: 1'b0, flip: 1'b0, bad: 1'b0};
        send(w);
        w.d = 9'h05A;
        send(w);
        check("R8 overwritten", rx_data, 9'h05A);
        check("R8 ovr_err", ovr_err, 1);
        check("R8 irq count", irq_cnt - irq0, 1);
        check("R10 err_sum ovr", err_sum, 1);
        read_pulse();
        check("R9 ovr cleared", ovr_err, 0);
        check("R9 sum cleared", err_sum, 0);

        // R9: a clean character rewrites the stale parity flag
        send(VECS[3]);
        check("R9 par set", par_err, 1);
        read_pulse();
        send(VECS[0]);
        check("R9 par rewritten", par_err, 0);
        read_pulse();

        // R3: a short low pulse is not a start bit
        irq0 = irq_cnt;
        @(negedge clk);
        hold(1'b0, 4 * (int'(reload) + 1));
        hold(1'b1, 40 * (int'(reload) + 1));
        check("R3 glitch no store", buf_full, 0);
        check("R3 glitch no irq", irq_cnt - irq0, 0);

        // R2: a slower bit rate through the reload value
        reload = 8'd3;
        repeat (8) @(negedge clk);
        w = '{d: 9'h0B6, len: 2'd1, par: 2'd2, two: 1'b0, flip: 1'b0, bad: 1'b0};
        send(w);
        check("R2 data at reload 3", rx_data, 9'h0B6);
        check("R2 no errors", err_sum, 0);
        read_pulse();

        finished = 1'b1;
        summary();
    end
endmodule